// File: doc/BRIEF.md
# DES Round Subkey Generator

This block expands a 64-bit DES key into the sixteen 48-bit round subkeys and hands them out one per clock, as a round datapath next to it consumes them. A one-cycle load pulse captures the key and the direction. The 56 key bits kept after the first permuted choice are held as two 28-bit halves. Each round the halves are rotated and reduced by the second permuted choice to that round's subkey.

For encryption the halves rotate left and the subkeys appear in round order 1 to 16. For decryption the halves rotate right, so the same sixteen subkeys appear in reverse order. No table of subkeys is stored, and there is nothing to read backwards. A done flag marks the last subkey of a run. The generator then holds its outputs until the next load.

Top module: `des_subkey_gen`

## Requirements
- R1: While reset is low and after it is released with no load, key_valid and done are 0, and round and subkey are all zeros.
- R2: On a clock edge with load high, the next cycle shows round = 1 and key_valid = 1. In encrypt mode (decrypt = 0 at the load) subkey then equals round subkey 1. Key bits are numbered 1 (MSB, key_in[63]) to 64 (LSB), and subkey bit 1 is subkey[47].
- R3: In encrypt mode, round increases by one each clock up to 16. Round r's subkey comes from halves rotated left by a running total, with a step of 1 in rounds 1, 2, 9 and 16 and of 2 in every other round.
- R4: In decrypt mode (decrypt = 1 at the load), the subkey shown with round r equals the encrypt-mode subkey of round 17 - r for the same key. Round 1 applies no rotation. Later rounds rotate right by 1 in rounds 2, 9 and 16 and by 2 otherwise.
- R5: done is 1 exactly in the cycle in which round = 16 and key_valid = 1. In the next cycle without a load, key_valid and done fall to 0, while round and subkey keep their values.
- R6: A load during a run restarts at round 1, using the new key and the new direction.
- R7: The decrypt input only matters at a load; changing it during a run does not change the subkey sequence.
- R8: key_in only matters at a load; changing it during a run or while idle does not change the outputs.
- R9: The eight parity bits (key bits 8, 16, ..., 64, the LSB of each byte) have no effect on any subkey.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture key_in and decrypt, start at round 1 |
| decrypt | input | 1 | Direction sampled at load: 0 = encrypt, 1 = decrypt |
| key_in | input | 64 | DES key including its parity bits |
| subkey | output | 48 | Registered subkey for the current round |
| round | output | 5 | Round number (1 to 16) that subkey belongs to |
| key_valid | output | 1 | subkey and round hold a live round |
| done | output | 1 | The sixteenth subkey is being presented |

## Verification
The assertions assume that load is a clean synchronous pulse and that the outputs may be left idle between runs for any length of time. They make no assumption about key_in or decrypt outside load cycles. The stimulus therefore changes both of those inputs freely during runs and while idle, and it also issues loads in the middle of runs and back to back. Expected subkeys come from a left-rotation-only model in the bench, which is read in reverse for decryption. This checks the right-rotation path against an independent ordering, and the bench also checks one published key/subkey pair.

// File: rtl/des_subkey_gen.sv
module des_subkey_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        decrypt,
  input  logic [63:0] key_in,
  output logic [47:0] subkey,
  output logic [4:0]  round,
  output logic        key_valid,
  output logic        done
);

  localparam int HALF = 28;
  localparam int LAST = 16;

  localparam int SEL1 [56] = '{57,49,41,33,25,17, 9, 1,58,50,42,34,26,18,
                               10, 2,59,51,43,35,27,19,11, 3,60,52,44,36,
                               63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
                               14, 6,61,53,45,37,29,21,13, 5,28,20,12, 4};
  localparam int SEL2 [48] = '{14,17,11,24, 1, 5, 3,28,15, 6,21,10,
                               23,19,12, 4,26, 8,16, 7,27,20,13, 2,
                               41,52,31,37,47,55,30,40,51,45,33,48,
                               44,49,39,56,34,53,46,42,50,36,29,32};

  function automatic logic [55:0] choose56(input logic [63:0] k);
    logic [55:0] o;
    for (int i = 0; i < 56; i++) o[55-i] = k[64-SEL1[i]];
    return o;
  endfunction

  function automatic logic [47:0] choose48(input logic [55:0] k);
    logic [47:0] o;
    for (int i = 0; i < 48; i++) o[47-i] = k[56-SEL2[i]];
    return o;
  endfunction

  function automatic logic [HALF-1:0] spin(input logic [HALF-1:0] x, input logic [1:0] n,
                                           input logic right);
    case ({right, n})
      3'b001:  return {x[HALF-2:0], x[HALF-1]};
      3'b010:  return {x[HALF-3:0], x[HALF-1:HALF-2]};
      3'b101:  return {x[0], x[HALF-1:1]};
      3'b110:  return {x[1:0], x[HALF-1:2]};
      default: return x;
    endcase
  endfunction

  logic [HALF-1:0] c_q, d_q;
  logic [47:0]     sub_q;
  logic [4:0]      rnd_q;
  logic            valid_q, mode_q;

  logic [55:0]     fresh;
  logic [HALF-1:0] c_base, d_base, c_nx, d_nx;
  logic [4:0]      nr;
  logic            mode_nx, short_step, advance;
  logic [1:0]      amt;

  assign fresh   = choose56(key_in);
  assign mode_nx = load ? decrypt : mode_q;
  assign c_base  = load ? fresh[55:28] : c_q;
  assign d_base  = load ? fresh[27:0]  : d_q;
  assign nr      = load ? 5'd1 : rnd_q + 5'd1;
  assign advance = load || (valid_q && rnd_q != 5'(LAST));

  assign short_step = (nr == 5'd1) || (nr == 5'd2) || (nr == 5'd9) || (nr == 5'd16);

  always_comb begin
    if (mode_nx && nr == 5'd1) amt = 2'd0;
    else if (short_step)       amt = 2'd1;
    else                       amt = 2'd2;
  end

  assign c_nx = spin(c_base, amt, mode_nx);
  assign d_nx = spin(d_base, amt, mode_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q     <= '0;
      d_q     <= '0;
      sub_q   <= '0;
      rnd_q   <= '0;
      valid_q <= 1'b0;
      mode_q  <= 1'b0;
    end else if (advance) begin
      c_q     <= c_nx;
      d_q     <= d_nx;
      sub_q   <= choose48({c_nx, d_nx});
      rnd_q   <= nr;
      valid_q <= 1'b1;
      mode_q  <= mode_nx;
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign subkey    = sub_q;
  assign round     = rnd_q;
  assign key_valid = valid_q;
  assign done      = valid_q && (rnd_q == 5'(LAST));

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (key_valid && round == 5'd1)); // R2

  AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !done && !load) |=> (key_valid && round == $past(round) + 5'd1)); // R3

  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (key_valid && round == 5'(LAST))); // R5

  AST_STOP_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !key_valid); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_valid && !load) |=> ($stable(subkey) && $stable(round) && !key_valid)); // R8

  AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (round >= 5'd1 && round <= 5'(LAST))); // R3

endmodule

// File: tb/tb_des_subkey_gen.sv
module tb_des_subkey_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic        decrypt = 1'b0;
  logic [63:0] key_in = '0;
  logic [47:0] subkey;
  logic [4:0]  round;
  logic        key_valid;
  logic        done;

  des_subkey_gen dut (
    .clk(clk), .rst_n(rst_n), .load(load), .decrypt(decrypt), .key_in(key_in),
    .subkey(subkey), .round(round), .key_valid(key_valid), .done(done)
  );

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  string req = "R1";

  int p1 [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,10,2,59,51,43,35,27,19,11,3,
                  60,52,44,36,63,55,47,39,31,23,15,7,62,54,46,38,30,22,14,6,61,53,45,37,
                  29,21,13,5,28,20,12,4};
  int p2 [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,26,8,16,7,27,20,13,2,
                  41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};
  int shifts [16] = '{1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1};

  logic [47:0] tab [1:16];
  logic        m_valid = 1'b0, m_dec = 1'b0;
  int          m_round = 0;
  logic [47:0] m_sub = '0;

  task automatic build(input logic [63:0] k);
    int bits [56];
    int c [28];
    int d [28];
    for (int i = 0; i < 56; i++) bits[i] = k[64 - p1[i]];
    for (int i = 0; i < 28; i++) begin c[i] = bits[i]; d[i] = bits[28 + i]; end
    for (int r = 1; r <= 16; r++) begin
      for (int s = 0; s < shifts[r-1]; s++) begin
        int tc = c[0];
        int td = d[0];
        for (int i = 0; i < 27; i++) begin c[i] = c[i+1]; d[i] = d[i+1]; end
        c[27] = tc; d[27] = td;
      end
      for (int i = 0; i < 48; i++) begin
        int src = p2[i] - 1;
        tab[r][47 - i] = (src < 28) ? c[src][0] : d[src - 28][0];
      end
    end
  endtask

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (load) begin
      build(key_in);
      m_dec = decrypt; m_round = 1; m_valid = 1'b1;
      m_sub = m_dec ? tab[16] : tab[1];
    end else if (m_valid && m_round < 16) begin
      m_round++;
      m_sub = m_dec ? tab[17 - m_round] : tab[m_round];
    end else begin
      m_valid = 1'b0;
    end
    @(negedge clk);
    check("subkey", {16'h0, subkey}, {16'h0, m_sub});
    check("round", {59'h0, round}, 64'(m_round));
    check("key_valid", {63'h0, key_valid}, {63'h0, m_valid});
    check("done", {63'h0, done}, {63'h0, (m_valid && m_round == 16)});
  endtask

  task automatic start(input logic [63:0] k, input logic dec);
    load = 1'b1; key_in = k; decrypt = dec;
    tick();
    load = 1'b0;
  endtask

  localparam logic [63:0] KNOWN = 64'h133457799BBCDFF1;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R1";
    check("reset subkey", {16'h0, subkey}, 64'h0);
    check("reset valid", {63'h0, key_valid}, 64'h0);
    check("reset done", {63'h0, done}, 64'h0);
    rst_n = 1'b1;
    repeat (3) tick();

    // R2 R3 R5: known key, encrypt
    req = "R2";
    start(KNOWN, 1'b0);
    check("K1 known", {16'h0, subkey}, 64'h1B02EFFC7072);
    req = "R3";
    repeat (14) tick();
    req = "R5";
    tick();
    check("K16 known", {16'h0, subkey}, 64'hCB3D8B0E17F5);
    check("done at 16", {63'h0, done}, 64'h1);
    tick();
    check("subkey held", {16'h0, subkey}, 64'hCB3D8B0E17F5);
    check("round held", {59'h0, round}, 64'd16);
    tick();

    // R4 decrypt of known key
    req = "R4";
    start(KNOWN, 1'b1);
    check("dec first", {16'h0, subkey}, 64'hCB3D8B0E17F5);
    repeat (15) tick();
    check("dec last", {16'h0, subkey}, 64'h1B02EFFC7072);
    repeat (2) tick();

    // R9 parity bits have no effect
    req = "R9";
    start(KNOWN ^ 64'h0101010101010101, 1'b0);
    check("parity K1", {16'h0, subkey}, 64'h1B02EFFC7072);
    repeat (16) tick();

    // R3 R4 several keys both directions
    for (int t = 0; t < 6; t++) begin
      logic [63:0] k = {$urandom(), $urandom()};
      req = (t % 2) ? "R4" : "R3";
      start(k, 1'(t % 2));
      repeat (17) tick();
    end

    // R7 R8: decrypt and key_in wiggle mid run and while idle
    req = "R7";
    start(64'h0123456789ABCDEF, 1'b1);
    for (int i = 0; i < 18; i++) begin
      decrypt = ~decrypt;
      req = (i % 2) ? "R8" : "R7";
      key_in = {$urandom(), $urandom()};
      tick();
    end
    req = "R8";
    repeat (4) begin key_in = ~key_in; tick(); end

    // R6 load mid run, direction change, back to back loads
    req = "R6";
    start(64'hFEDCBA9876543210, 1'b0);
    repeat (5) tick();
    start(64'h0E329232EA6D0D73, 1'b1);
    start(KNOWN, 1'b0);
    check("restart K1", {16'h0, subkey}, 64'h1B02EFFC7072);
    repeat (7) tick();
    start(64'hA5A5A5A55A5A5A5A, 1'b1);
    repeat (18) tick();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule